// File: doc/BRIEF.md
# Supply Power-Good Fault Monitor

This block watches the power-good signals of three switchable supply rails: a 12 V main rail, a GPU core rail and a CPU core rail. Each rail has an enable command, and a ramp-time budget counted in millisecond ticks. Once a rail is enabled, the block arms that rail's fault detection. It arms when the rail's power-good is seen high or when the ramp budget runs out, whichever happens first. The main rail does not arm the moment power-good is seen. It waits a settling window first, bounded between 2 ms and 25 ms.

When a rail is armed, a low power-good produces a one-cycle error strobe together with that rail's own error code. The code stays on the output until software-side logic clears it. Power-good inputs are asynchronous and pass through a two-flop synchronizer. Turning a rail's enable off disarms the rail and clears its timers, so a deliberate power-down is never reported as a fault. The block does not decide which rails to turn on, and it does not shut rails down.

Top module: `pg_fault_mon`

## Requirements
- R1: The main and CPU enables are active-high and the GPU enable (`en_gpu_n`) is active-low; a disabled rail never arms, whatever its power-good level and however many ticks arrive.
- R2: With power-good held low, an enabled rail arms on the clock edge that samples the RAMP-th millisecond tick after enable (RAMP = 8 main, 5 GPU, 6 CPU by default).
- R3: A GPU or CPU rail whose synchronized power-good is high arms without waiting for ticks: the `armed` bit rises two clock edges after the enable changes, when power-good was already high.
- R4: Once the main rail sees power-good high, it arms on the (SETTLE+1)-th tick after that (SETTLE = 3 by default), and the ramp budget no longer arms it, even if the budget would have expired sooner.
- R5: The SETTLE parameter is checked at elaboration to lie in 2..24, so the real settling delay (between SETTLE and SETTLE+1 ms) stays within 2..25 ms.
- R6: An armed rail whose power-good goes low raises `err_valid` for exactly one cycle, on the third clock edge after the input falls. `err_code` then shows 1 for main, 2 for GPU and 3 for CPU. The rail drops `armed` and reports nothing more until it is disabled and enabled again.
- R7: If several rails fault in the same cycle, the code reported is that of the lowest-indexed rail (main before GPU before CPU).
- R8: `err_code` is 0 after reset and holds its value until `err_clr` is sampled high, which sets it to 0. A fault arriving in the same cycle as the clear takes precedence and loads its code.
- R9: Deasserting a rail's enable disarms it at once and restarts its ramp and settle timers, and a power-good drop that arrives together with the disable produces no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| en_main | input | 1 | Main 12 V rail enable, active-high |
| en_gpu_n | input | 1 | GPU core rail enable, active-low |
| en_cpu | input | 1 | CPU core rail enable, active-high |
| pg_main | input | 1 | Main rail power-good, asynchronous |
| pg_gpu | input | 1 | GPU rail power-good, asynchronous |
| pg_cpu | input | 1 | CPU rail power-good, asynchronous |
| err_clr | input | 1 | Clears the held error code |
| armed | output | 3 | Per-rail armed flag: bit 0 main, bit 1 GPU, bit 2 CPU |
| err_valid | output | 1 | One-cycle fault strobe |
| err_code | output | 2 | Held code: 0 none, 1 main, 2 GPU, 3 CPU |

## Verification
The bench sweeps each rail's ramp limit to the exact tick. A counter that is off by one arms a tick early or a tick late, and the check sees the armed flag one tick too soon or too late. The main rail's settle window is swept against every point at which the ramp budget could have been partly used. A design that let the ramp timeout keep running after power-good was seen would arm before the settle count ended.

Every combination of rails failing together is applied, and one of these faults lands in the same cycle as a clear. A wrong priority shows up as the wrong code, and a clear that beats the fault leaves the code at 0. The bench also disables a rail partway through its ramp and again at the same moment its power-good drops. A timer that is not restarted arms early, and a disable that does not take effect first produces a false error strobe.

// File: rtl/pgmon_pkg.sv
package pgmon_pkg;

    localparam int NRAIL  = 3;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        ERR_NONE   = 2'd0,
        ERR_MAIN12 = 2'd1,
        ERR_GPU    = 2'd2,
        ERR_CPU    = 2'd3
    } err_code_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RAMP,
        ST_SETTLE,
        ST_ARMED,
        ST_TRIPPED
    } rail_state_e;

    // Code of the lowest-indexed set bit; rail i maps to code i+1.
    function automatic err_code_e lowest_code(input logic [NRAIL-1:0] m);
        err_code_e c;
        c = ERR_NONE;
        for (int i = NRAIL - 1; i >= 0; i--) begin
            if (m[i]) c = err_code_e'(CODE_W'(i + 1));
        end
        return c;
    endfunction

endpackage

// File: rtl/pgmon_sync.sv
module pgmon_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pgmon_rail.sv
module pgmon_rail
    import pgmon_pkg::*;
#(
    parameter int RAMP_MS    = 8,
    parameter int SETTLE_MS  = 3,
    parameter bit USE_SETTLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic en,
    input  logic pg,
    output logic armed_o,
    output logic fault_o
);
    localparam int LIMIT = (RAMP_MS > SETTLE_MS) ? RAMP_MS : SETTLE_MS;
    localparam int CW    = $clog2(LIMIT + 1);

    rail_state_e     st;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st  <= ST_OFF;
            cnt <= '0;
        end else begin
            unique case (st)
                ST_OFF: begin
                    st  <= ST_RAMP;
                    cnt <= '0;
                end
                ST_RAMP: begin
                    if (pg) begin
                        st  <= USE_SETTLE ? ST_SETTLE : ST_ARMED;
                        cnt <= '0;
                    end else if (tick) begin
                        if (cnt == CW'(RAMP_MS - 1)) begin
                            st  <= ST_ARMED;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (!pg) begin
                        st  <= ST_RAMP;
                        cnt <= '0;
                    end else if (tick) begin
                        if (cnt == CW'(SETTLE_MS)) begin
                            st  <= ST_ARMED;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_ARMED: begin
                    if (!pg) st <= ST_TRIPPED;
                end
                default: st <= ST_TRIPPED;
            endcase
        end
    end

    assign armed_o = (st == ST_ARMED);
    assign fault_o = armed_o && !pg;

    AST_ARM_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        armed_o |-> $past(en)); // R9
    AST_TRIP_LATCHES: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> !armed_o); // R6
endmodule

// File: rtl/pgmon_report.sv
module pgmon_report
    import pgmon_pkg::*;
#(
    parameter int N = NRAIL
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    fault,
    input  logic            clr,
    output logic            err_valid,
    output err_code_e       err_code
);
    logic any_fault;
    assign any_fault = |fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            err_valid <= any_fault;
            if (any_fault)  err_code <= lowest_code(fault);
            else if (clr)   err_code <= ERR_NONE;
        end
    end

    AST_VALID_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_code != ERR_NONE)); // R6
    AST_MAIN_WINS: assert property (@(posedge clk) disable iff (rst)
        fault[0] |=> (err_code == ERR_MAIN12)); // R7
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (clr && !any_fault) |=> (err_code == ERR_NONE)); // R8
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !any_fault) |=> $stable(err_code)); // R8
endmodule

// File: rtl/pg_fault_mon.sv
module pg_fault_mon
    import pgmon_pkg::*;
#(
    parameter int RAMP_MAIN_MS = 8,
    parameter int RAMP_GPU_MS  = 5,
    parameter int RAMP_CPU_MS  = 6,
    parameter int SETTLE_MS    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_tick,
    input  logic              en_main,
    input  logic              en_gpu_n,
    input  logic              en_cpu,
    input  logic              pg_main,
    input  logic              pg_gpu,
    input  logic              pg_cpu,
    input  logic              err_clr,
    output logic [NRAIL-1:0]  armed,
    output logic              err_valid,
    output logic [CODE_W-1:0] err_code
);
    // R5: settling delay between SETTLE_MS and SETTLE_MS+1 ms must sit in 2..25 ms
    if (SETTLE_MS < 2 || SETTLE_MS > 24) begin : g_bad_settle
        $fatal(1, "SETTLE_MS out of range 2..24");
    end

    logic [NRAIL-1:0] en_act;
    logic [NRAIL-1:0] pg_raw;
    logic [NRAIL-1:0] pg_s;
    logic [NRAIL-1:0] fault;
    err_code_e        code_q;

    assign en_act = {en_cpu, ~en_gpu_n, en_main};
    assign pg_raw = {pg_cpu, pg_gpu, pg_main};

    pgmon_sync #(.W(NRAIL)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pg_raw),
        .q   (pg_s)
    );

    for (genvar i = 0; i < NRAIL; i++) begin : g_rail
        localparam int RAMP_I = (i == 0) ? RAMP_MAIN_MS :
                                (i == 1) ? RAMP_GPU_MS  : RAMP_CPU_MS;
        pgmon_rail #(
            .RAMP_MS    (RAMP_I),
            .SETTLE_MS  (SETTLE_MS),
            .USE_SETTLE (i == 0)
        ) u_rail (
            .clk     (clk),
            .rst     (rst),
            .tick    (ms_tick),
            .en      (en_act[i]),
            .pg      (pg_s[i]),
            .armed_o (armed[i]),
            .fault_o (fault[i])
        );
    end

    pgmon_report #(.N(NRAIL)) u_report (
        .clk       (clk),
        .rst       (rst),
        .fault     (fault),
        .clr       (err_clr),
        .err_valid (err_valid),
        .err_code  (code_q)
    );

    assign err_code = code_q;

    AST_GPU_ACTIVE_LOW: assert property (@(posedge clk) disable iff (rst)
        armed[1] |-> !$past(en_gpu_n)); // R1
endmodule

// File: tb/sim_pg_fault_mon.sv
module sim_pg_fault_mon;
    localparam int SETTLE = 3;
    localparam int RAMP0 = 8;
    localparam int RAMP1 = 5;
    localparam int RAMP2 = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 1'b0;
    logic en_main = 1'b0, en_gpu_n = 1'b1, en_cpu = 1'b0;
    logic pg_main = 1'b0, pg_gpu = 1'b0, pg_cpu = 1'b0;
    logic err_clr = 1'b0;
    logic [2:0] armed;
    logic err_valid;
    logic [1:0] err_code;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pg_fault_mon u0 (
        .clk(clk), .rst(rst), .ms_tick(ms_tick),
        .en_main(en_main), .en_gpu_n(en_gpu_n), .en_cpu(en_cpu),
        .pg_main(pg_main), .pg_gpu(pg_gpu), .pg_cpu(pg_cpu),
        .err_clr(err_clr), .armed(armed), .err_valid(err_valid),
        .err_code(err_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ramp_of(input int r);
        return (r == 0) ? RAMP0 : (r == 1) ? RAMP1 : RAMP2;
    endfunction

    task automatic set_en(input int r, input logic v);
        case (r)
            0: en_main = v;
            1: en_gpu_n = ~v;
            default: en_cpu = v;
        endcase
    endtask

    task automatic set_pg(input int r, input logic v);
        case (r)
            0: pg_main = v;
            1: pg_gpu = v;
            default: pg_cpu = v;
        endcase
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick1;
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    task automatic clear_code;
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        chk("R8 reset code", int'(err_code), 0);
        chk("R6 reset valid", int'(err_valid), 0);
        chk("R1 reset armed", int'(armed), 0);

        // R1: GPU disabled with en_gpu_n high never arms
        pg_gpu = 1'b1;
        wait_n(3);
        repeat (10) tick1;
        chk("R1 disabled rails stay unarmed", int'(armed), 0);
        chk("R1 disabled rails no error", int'(err_valid), 0);
        @(negedge clk) en_gpu_n = 1'b0;
        @(negedge clk);
        chk("R3 gpu not armed after one edge", int'(armed[1]), 0);
        @(negedge clk);
        chk("R3 gpu armed on power-good", int'(armed[1]), 1);
        @(negedge clk) en_gpu_n = 1'b1;
        pg_gpu = 1'b0;
        wait_n(4);

        // R2: ramp timeout sweep per rail
        for (int r = 0; r < 3; r++) begin
            @(negedge clk) set_en(r, 1'b1);
            repeat (ramp_of(r) - 1) tick1;
            chk("R2 not armed before ramp limit", int'(armed[r]), 0);
            tick1;
            chk("R2 armed at ramp limit", int'(armed[r]), 1);
            @(negedge clk);
            chk("R6 strobe after timeout arm", int'(err_valid), 1);
            chk("R6 rail code", int'(err_code), r + 1);
            @(negedge clk);
            chk("R6 strobe one cycle", int'(err_valid), 0);
            chk("R6 rail tripped", int'(armed[r]), 0);
            chk("R8 code held", int'(err_code), r + 1);
            wait_n(3);
            chk("R6 no repeat report", int'(err_valid), 0);
            clear_code;
            chk("R8 clear sets none", int'(err_code), 0);
            @(negedge clk) set_en(r, 1'b0);
            wait_n(3);
        end

        // R4: main settle window vs partly used ramp budget
        for (int p = 0; p < RAMP0; p++) begin
            @(negedge clk) en_main = 1'b1;
            repeat (p) tick1;
            @(negedge clk) pg_main = 1'b1;
            wait_n(3);
            repeat (SETTLE) tick1;
            chk("R4 main not armed inside settle", int'(armed[0]), 0);
            tick1;
            chk("R4 main armed after settle", int'(armed[0]), 1);
            @(negedge clk) en_main = 1'b0;
            pg_main = 1'b0;
            wait_n(4);
            chk("R9 main disable no error", int'(err_valid), 0);
        end

        // R7: every combination of simultaneous faults
        for (int m = 1; m < 8; m++) begin
            int expc;
            expc = (m & 1) ? 1 : (m & 2) ? 2 : 3;
            pg_main = 1'b1; pg_gpu = 1'b1; pg_cpu = 1'b1;
            wait_n(3);
            @(negedge clk) begin en_main = 1'b1; en_gpu_n = 1'b0; en_cpu = 1'b1; end
            wait_n(2);
            repeat (SETTLE + 1) tick1;
            chk("R4 all rails armed", int'(armed), 7);
            @(negedge clk);
            for (int r = 0; r < 3; r++) if (m & (1 << r)) set_pg(r, 1'b0);
            wait_n(2);
            if (m == 6) err_clr = 1'b1;
            @(negedge clk) err_clr = 1'b0;
            chk("R7 strobe on multi fault", int'(err_valid), 1);
            chk("R7 lowest rail code", int'(err_code), expc);
            @(negedge clk);
            chk("R6 only faulted rails trip", int'(armed), 7 & ~m);
            if (m == 6) chk("R8 fault beats clear", int'(err_code), expc);
            @(negedge clk) begin en_main = 1'b0; en_gpu_n = 1'b1; en_cpu = 1'b0; end
            pg_main = 1'b0; pg_gpu = 1'b0; pg_cpu = 1'b0;
            wait_n(3);
            clear_code;
        end

        // R9: disable mid-ramp restarts the timer
        pg_cpu = 1'b0;
        @(negedge clk) en_cpu = 1'b1;
        repeat (RAMP2 - 1) tick1;
        @(negedge clk) en_cpu = 1'b0;
        wait_n(2);
        @(negedge clk) en_cpu = 1'b1;
        repeat (RAMP2 - 1) tick1;
        chk("R9 timer restarted", int'(armed[2]), 0);
        tick1;
        chk("R9 arms after full ramp", int'(armed[2]), 1);
        @(negedge clk);
        chk("R6 cpu code", int'(err_code), 3);
        @(negedge clk) en_cpu = 1'b0;
        wait_n(3);
        clear_code;

        // R9: disable together with power-good drop gives no error
        pg_cpu = 1'b1;
        wait_n(3);
        @(negedge clk) en_cpu = 1'b1;
        wait_n(3);
        chk("R3 cpu armed on power-good", int'(armed[2]), 1);
        @(negedge clk) begin en_cpu = 1'b0; pg_cpu = 1'b0; end
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (err_valid) seen++;
            end
            chk("R9 no strobe on disable", seen, 0);
        end
        chk("R9 disarmed", int'(armed), 0);
        chk("R9 code untouched", int'(err_code), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule